// File: doc/BRIEF.md
# Asynchronous Memory Bus Controller

This block connects a clocked host to an asynchronous, 16-bit wide, byte-selectable static memory. The host posts a single read or write per request, with an address, write data and a two-bit byte mask. The controller then steps the memory's active-low chip enable, write enable, output enable and two byte selects through a timed sequence. Each phase of that sequence lasts a whole number of clock cycles. The counts come from parameters that give the memory's nanosecond limits and the clock period.

Reads hold chip enable, output enable and the chosen byte selects low for the access time. The controller then captures the memory's data, pulses `done` and raises every strobe together. Writes are always ended by write enable. Output enable stays high for the whole write. The host data driver turns on after the memory has floated its pins and turns off one clock after write enable rises. The address is held through a recovery period before `ready` returns. After reset the controller keeps every strobe high for a power-up lockout, and it refuses all requests until that lockout ends.

Top module: `async_mem_ctrl`

## Requirements
- R1: From reset until LOCK_C clock edges have passed (ceil of the lockout time over the clock period), `ready` is low, `mem_ce_n` and `mem_we_n` are high, and requests are dropped.
- R2: A read accepted at edge E0 drives `mem_ce_n`, `mem_oe_n` and the selected byte selects low from E0 until edge E0+ACC_C (2 at defaults). `mem_we_n` stays high for the whole read.
- R3: At the edge that ends a read access, `rdata` takes the memory data with every unselected lane forced to zero. `done` is high for exactly that one cycle, and all strobes are high in that cycle.
- R4: A write accepted at E0 drives `mem_ce_n`, `mem_we_n` and the selected byte selects low at that same edge, with the new address. They stay low until E0+WP_C (2 at defaults). `mem_oe_n` stays high for the whole write.
- R5: `mem_dout_en` rises DZ_C edges (1 at defaults) after write enable falls and falls one edge after write enable rises. While it is high, `mem_dout` holds the request's write data unchanged.
- R6: `done` pulses for one cycle at the edge where write enable rises.
- R7: After `done`, the address is held and all strobes stay high for the recovery count (1 cycle at defaults). After that, `ready` returns high.
- R8: A request presented while `ready` is low is ignored. It does not change the address, strobes or data outputs.
- R9: Byte mask bit 1 selects the upper lane (data bits 15:8, `mem_ub_n`) and bit 0 selects the lower lane (bits 7:0, `mem_lb_n`). A mask of 00 still runs a full cycle, but no byte select falls.
- R10: While chip enable stays low, `mem_addr` is stable. Every access keeps the address for at least the minimum cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request, taken on an edge while `ready` is high |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Word address |
| wdata | input | 16 | Write data |
| be | input | 2 | Byte mask, bit 1 upper lane, bit 0 lower lane |
| ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last read data, unselected lanes zero |
| mem_addr | output | AW | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_dout | output | 16 | Data toward the memory |
| mem_dout_en | output | 1 | Enable for the host data driver |
| mem_din | input | 16 | Data from the memory |

## Verification
With the default timing, a request taken at edge E0 changes the strobes at E0 itself. The data driver turns on at E0+1. `done`, the strobe release and the read capture all land at E0+2. The driver turns off and `ready` returns at E0+3. The lockout ends exactly LOCK_C edges after reset is released. The bench's reference model keeps a count of edges since acceptance and derives every expected output from that count. All outputs are sampled at the falling clock edge, so each registered result is compared in the first half-cycle after the edge that produces it. Written data reaches the bench's memory only through the strobes and data pins, so a write that lands on the wrong lane shows up in a later read.

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl #(
  parameter int AW           = 16,
  parameter int CLK_NS       = 20,
  parameter int T_CYCLE_NS   = 35,
  parameter int T_ACCESS_NS  = 35,
  parameter int T_WPULSE_NS  = 15,
  parameter int T_ADDR_END_NS = 18,
  parameter int T_DSETUP_NS  = 10,
  parameter int T_RELEASE_NS = 12,
  parameter int T_FLOAT_NS   = 15,
  parameter int T_RECOV_NS   = 12,
  parameter int T_HIGH_NS    = 2,
  parameter int T_LOCK_NS    = 2000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  input  logic [1:0]    be,
  output logic          ready,
  output logic          done,
  output logic [15:0]   rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic [15:0]   mem_dout,
  output logic          mem_dout_en,
  input  logic [15:0]   mem_din
);

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int ACC_C  = imax(1, cdiv(T_ACCESS_NS, CLK_NS));
  localparam int DZ_C   = imax(1, cdiv(T_RELEASE_NS, CLK_NS));
  localparam int WP_C   = imax(imax(cdiv(T_WPULSE_NS, CLK_NS), cdiv(T_ADDR_END_NS, CLK_NS)),
                               DZ_C + imax(1, cdiv(T_DSETUP_NS, CLK_NS)));
  localparam int CYC_C  = cdiv(T_CYCLE_NS, CLK_NS);
  localparam int REC_C  = imax(imax(1, cdiv(T_RECOV_NS, CLK_NS)),
                               imax(cdiv(T_FLOAT_NS, CLK_NS), cdiv(T_HIGH_NS, CLK_NS)));
  localparam int RECW_C = imax(REC_C, CYC_C - WP_C);
  localparam int RECR_C = imax(REC_C, CYC_C - ACC_C);
  localparam int LOCK_C = imax(1, cdiv(T_LOCK_NS, CLK_NS));
  localparam int MAX_C  = imax(imax(LOCK_C, WP_C), imax(ACC_C, imax(RECW_C, RECR_C)));
  localparam int CW     = $clog2(MAX_C + 1);

  typedef enum logic [2:0] {ST_LOCK, ST_IDLE, ST_READ, ST_WRITE, ST_RECOV} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [15:0]   lane_mask;

  assign ready     = (st == ST_IDLE);
  assign lane_mask = {{8{~mem_ub_n}}, {8{~mem_lb_n}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_LOCK;
      cnt         <= CW'(LOCK_C - 1);
      done        <= 1'b0;
      rdata       <= '0;
      mem_addr    <= '0;
      mem_ce_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_oe_n    <= 1'b1;
      mem_ub_n    <= 1'b1;
      mem_lb_n    <= 1'b1;
      mem_dout    <= '0;
      mem_dout_en <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_LOCK: begin
          if (cnt == '0) st <= ST_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        ST_IDLE: begin
          if (req) begin
            mem_addr <= addr;
            mem_ce_n <= 1'b0;
            mem_ub_n <= ~be[1];
            mem_lb_n <= ~be[0];
            if (wr) begin
              mem_we_n <= 1'b0;
              mem_dout <= wdata;
              cnt      <= CW'(WP_C - 1);
              st       <= ST_WRITE;
            end else begin
              mem_oe_n <= 1'b0;
              cnt      <= CW'(ACC_C - 1);
              st       <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (cnt == '0) begin
            rdata    <= mem_din & lane_mask;
            done     <= 1'b1;
            mem_ce_n <= 1'b1;
            mem_oe_n <= 1'b1;
            mem_ub_n <= 1'b1;
            mem_lb_n <= 1'b1;
            cnt      <= CW'(RECR_C - 1);
            st       <= ST_RECOV;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WRITE: begin
          if (cnt == CW'(WP_C - DZ_C)) mem_dout_en <= 1'b1;
          if (cnt == '0) begin
            done     <= 1'b1;
            mem_ce_n <= 1'b1;
            mem_we_n <= 1'b1;
            mem_ub_n <= 1'b1;
            mem_lb_n <= 1'b1;
            cnt      <= CW'(RECW_C - 1);
            st       <= ST_RECOV;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_RECOV: begin
          mem_dout_en <= 1'b0;
          if (cnt == '0) st <= ST_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/async_mem_ctrl_chk.sv
module async_mem_ctrl_chk #(
  parameter int AW     = 16,
  parameter int LOCK_N = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          ready,
  input logic          done,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic [15:0]   mem_dout,
  input logic          mem_dout_en
);

  localparam int KW = $clog2(LOCK_N + 2);
  logic [KW-1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         since_rst <= '0;
    else if (since_rst < KW'(LOCK_N))   since_rst <= since_rst + 1'b1;
  end

  AST_LOCKOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < KW'(LOCK_N)) |-> (mem_ce_n && mem_we_n && !ready)); // R1
  AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n); // R4
  AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n); // R4
  AST_DRIVE_ONLY_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> mem_oe_n); // R5
  AST_DRIVE_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dout_en && $past(mem_dout_en)) |-> $stable(mem_dout)); // R5
  AST_DRIVE_OFF_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_dout_en) |-> $past(mem_we_n)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_DONE_STROBES_UP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_ce_n && mem_we_n && mem_oe_n)); // R3
  AST_WE_RISE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> done); // R6
  AST_ACCEPT_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req) |=> !mem_ce_n); // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R10

endmodule

bind async_mem_ctrl async_mem_ctrl_chk #(.AW(AW), .LOCK_N(LOCK_C)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .done(done),
  .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en)
);

// File: tb/async_mem_ctrl_test.sv
module async_mem_ctrl_test;
  localparam int LOCK = 50;
  localparam int ACC  = 2;
  localparam int WP   = 2;
  localparam int DZ   = 1;
  localparam int REC  = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic [1:0] be = '0;
  logic ready, done, mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dout_en;
  logic [15:0] rdata, mem_addr, mem_dout, mem_din;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  async_mem_ctrl #(.T_LOCK_NS(1000)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata), .be(be),
    .ready(ready), .done(done), .rdata(rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_dout(mem_dout),
    .mem_dout_en(mem_dout_en), .mem_din(mem_din)
  );

  logic [15:0] mem [256];
  logic [15:0] shadow [256];
  initial for (int i = 0; i < 256; i++) begin
    mem[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
    shadow[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
  end

  assign mem_din = (!mem_ce_n && !mem_oe_n) ? mem[mem_addr[7:0]] : 16'h0000;

  bit p_on = 0, p_u = 0, p_l = 0;
  logic [7:0] p_a;
  logic [15:0] p_d;
  always @(negedge clk) begin
    if (!mem_ce_n && !mem_we_n) begin
      if (mem_dout_en) begin
        p_on = 1; p_a = mem_addr[7:0]; p_d = mem_dout; p_u = !mem_ub_n; p_l = !mem_lb_n;
      end
    end else if (p_on) begin
      if (p_u) mem[p_a][15:8] = p_d[15:8];
      if (p_l) mem[p_a][7:0]  = p_d[7:0];
      p_on = 0;
    end
  end

  int m_pwr = LOCK, m_t = 0;
  bit m_busy = 0, m_wr = 0;
  logic [15:0] m_addr = '0, m_wd = '0, m_rd = '0;
  logic [1:0] m_be = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pwr = LOCK; m_busy = 0; m_t = 0; m_addr = '0; m_rd = '0;
    end else if (m_pwr > 0) begin
      m_pwr--;
    end else if (!m_busy) begin
      if (req) begin
        m_busy = 1; m_t = 0; m_wr = wr; m_addr = addr; m_wd = wdata; m_be = be;
      end
    end else begin
      m_t++;
      if (m_wr && m_t == WP) begin
        if (m_be[1]) shadow[m_addr[7:0]][15:8] = m_wd[15:8];
        if (m_be[0]) shadow[m_addr[7:0]][7:0]  = m_wd[7:0];
      end
      if (!m_wr && m_t == ACC)
        m_rd = shadow[m_addr[7:0]] & {{8{m_be[1]}}, {8{m_be[0]}}};
      if (m_t == (m_wr ? WP : ACC) + REC) m_busy = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int endt;
      bit act_ph;
      endt   = m_wr ? WP : ACC;
      act_ph = m_busy && (m_t < endt);
      chk(ready == (m_pwr == 0 && !m_busy), "R7 ready", 32'(ready), 32'(m_pwr == 0 && !m_busy));
      chk(mem_ce_n == !act_ph, "R2 ce_n", 32'(mem_ce_n), 32'(!act_ph));
      chk(mem_we_n == !(act_ph && m_wr), "R4 we_n", 32'(mem_we_n), 32'(!(act_ph && m_wr)));
      chk(mem_oe_n == !(act_ph && !m_wr), "R2 oe_n", 32'(mem_oe_n), 32'(!(act_ph && !m_wr)));
      chk(mem_ub_n == !(act_ph && m_be[1]), "R9 ub_n", 32'(mem_ub_n), 32'(!(act_ph && m_be[1])));
      chk(mem_lb_n == !(act_ph && m_be[0]), "R9 lb_n", 32'(mem_lb_n), 32'(!(act_ph && m_be[0])));
      chk(mem_dout_en == (m_busy && m_wr && m_t >= DZ && m_t <= WP), "R5 dout_en",
          32'(mem_dout_en), 32'(m_busy && m_wr && m_t >= DZ && m_t <= WP));
      if (mem_dout_en) chk(mem_dout == m_wd, "R5 dout", 32'(mem_dout), 32'(m_wd));
      chk(done == (m_busy && m_t == endt), m_wr ? "R6 done" : "R3 done",
          32'(done), 32'(m_busy && m_t == endt));
      chk(rdata == m_rd, "R3 rdata", 32'(rdata), 32'(m_rd));
      chk(mem_addr == m_addr, "R10 addr", 32'(mem_addr), 32'(m_addr));
    end
  end

  task automatic do_op(input bit w, input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] m, input bit noise);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1; wr = w; addr = a; wdata = d; be = m;
    @(negedge clk);
    if (noise) begin
      wr = !w; addr = a + 16'd1; wdata = ~d; be = ~m;
      @(negedge clk);
      chk(mem_addr == a, "R8 busy req ignored", 32'(mem_addr), 32'(a));
    end
    req = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !ready && !done, "R1 reset state",
        32'({mem_ce_n, mem_we_n, mem_oe_n, ready, done}), 32'b11100);
    rst_n = 1;
    req = 1; wr = 1; addr = 16'h0005; wdata = 16'hFFFF; be = 2'b11;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(!ready && mem_ce_n && mem_we_n, "R1 lockout", 32'({ready, mem_ce_n, mem_we_n}), 32'b011);
    end
    req = 0;
    do_op(1, 16'h0010, 16'hBEEF, 2'b11, 0);
    do_op(1, 16'h0011, 16'h1234, 2'b01, 1);
    do_op(1, 16'h0012, 16'hABCD, 2'b10, 0);
    do_op(1, 16'h0013, 16'h7777, 2'b00, 0);
    do_op(0, 16'h0010, 16'h0000, 2'b11, 0);
    do_op(0, 16'h0011, 16'h0000, 2'b11, 1);
    do_op(0, 16'h0012, 16'h0000, 2'b11, 0);
    do_op(0, 16'h0013, 16'h0000, 2'b11, 0);
    do_op(0, 16'h0010, 16'h0000, 2'b01, 0);
    do_op(0, 16'h0010, 16'h0000, 2'b10, 1);
    do_op(0, 16'h0010, 16'h0000, 2'b00, 0);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1; wr = 0; addr = 16'h0020; be = 2'b11;
    repeat (12) @(negedge clk);
    req = 1; wr = 1; addr = 16'h0020; wdata = 16'h0F0F; be = 2'b01;
    repeat (6) @(negedge clk);
    req = 0;
    do_op(0, 16'h0020, 16'h0000, 2'b11, 0);
    repeat (6) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule